// File: doc/BRIEF.md
# Seconds Counter with Alarm Matching

This block is a memory-mapped elapsed-seconds timer. A one-cycle pulse on a separate tick input, nominally once per second, advances a 32-bit up-counter and steps a companion down-counter the other way, so that software which loads both as a pair sees two views of the same time. Two 32-bit compare registers watch the up-counter. When the count reaches a compare value, a sticky status bit is raised. That bit can raise the interrupt line, drive the power-on output, or both, depending on the control register.

Software reads and writes the registers over a simple single-cycle bus. A write takes effect on the clock edge where the request and write-enable are both high. Read data is a combinational function of the address. The bus has no back-pressure: every request completes in the cycle it is presented, so there is no ready signal. A 32-bit scratch key register survives the software counter reset. Firmware stores a marker value there to record that first-time setup is already done.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset the up-counter reads 0, the down-counter reads 0xFFFFFFFF, both compare registers read 0xFFFFFFFF, and control, status and key read 0. irq_o and pwr_on_o are low. Byte offsets are: up 0x00, down 0x04, compare A 0x08, compare B 0x0C, control 0x10, status 0x14, key 0x18. Any other word reads 0.
- R2: Each cycle with tick_i high, the up-counter increments by one and the down-counter decrements by one, provided counting is enabled.
- R3: While control bit 6 (freeze) is set, ticks change neither counter. Software can still load both counters by bus writes.
- R4: A bus write to a counter in the same cycle as a tick stores the written value in that counter. The counter that is not written still advances.
- R5: While control bit 4 (counter clear) is set, the up-counter is held at 0 and the down-counter at 0xFFFFFFFF, and ticks and counter writes have no effect. The compare and key registers keep their values.
- R6: Status bit 0 (compare A) and bit 1 (compare B) become 1 one cycle after the up-counter equals that compare register, and they stay set. Writing 1 to a status bit clears it. The clear has no effect while the equality still holds.
- R7: irq_o is high exactly when status bit 0 and control bit 0 are both set, or when status bit 1 and control bit 1 are both set.
- R8: pwr_on_o is high when control bit 7 (force) is set. It is also high when status bit 0 is set with control bit 2, or status bit 1 is set with control bit 3.
- R9: Status bit 2 is set one cycle after pwr_on_o rises, and it stays set until it is cleared by writing 1.
- R10: The key register stores all 32 bits written to it. Control bit 5 and control bits 8 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle seconds tick |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 5 | Byte address; bits 1:0 ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| pwr_on_o | output | 1 | Power-on switch output |

## Verification
The bench drives a counter write and a tick in the same cycle. A design that let the tick win would show the old value plus one, and a design that stalled the other counter would leave the down-counter unchanged. The bench clears a compare status while the count still equals the compare value. A design that let the clear win would drop the bit while the alarm condition is still true. The bench also enables the interrupt mask only after the status bit has latched, and it routes a compare event to the power-on output. This exposes a gate that samples the enable only at match time, or a power-on event bit that latches on level instead of on the rising edge. Finally, the counter clear is held across a tick with the key and compare registers loaded. This catches a clear that also wipes those registers, or one that lets the tick through.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // word indices (byte offset / 4)
  localparam logic [2:0] IDX_UP   = 3'd0;
  localparam logic [2:0] IDX_DOWN = 3'd1;
  localparam logic [2:0] IDX_CMPA = 3'd2;
  localparam logic [2:0] IDX_CMPB = 3'd3;
  localparam logic [2:0] IDX_CTRL = 3'd4;
  localparam logic [2:0] IDX_STAT = 3'd5;
  localparam logic [2:0] IDX_KEY  = 3'd6;

  localparam int NUM_CMP  = 2;
  localparam int CTRL_W   = 8;
  localparam int STAT_W   = 3;

  // control bit positions
  localparam int CB_IRQ_EN0 = 0;
  localparam int CB_ROUTE0  = 2;
  localparam int CB_CLEAR   = 4;
  localparam int CB_FREEZE  = 6;
  localparam int CB_FORCE   = 7;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hDF;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         freeze,
  input  logic         tick,
  input  logic         ld_up,
  input  logic         ld_dn,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] up_cnt,
  output logic [W-1:0] dn_cnt
);
  localparam logic [W-1:0] ONE = W'(1);
  logic step;
  assign step = tick & ~freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
      dn_cnt <= '1;
    end else if (clear) begin
      up_cnt <= '0;
      dn_cnt <= '1;
    end else begin
      if (ld_up)     up_cnt <= ld_val;
      else if (step) up_cnt <= up_cnt + ONE;
      if (ld_dn)     dn_cnt <= ld_val;
      else if (step) dn_cnt <= dn_cnt - ONE;
    end
  end
endmodule

// File: rtl/sat_match.sv
module sat_match #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        up_cnt,
  input  logic [N-1:0][W-1:0] cmp_val,
  input  logic [N-1:0]        clr,
  output logic [N-1:0]        hit
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic eq;
    assign eq = (up_cnt == cmp_val[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit[i] <= 1'b0;
      else        hit[i] <= eq | (hit[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/sat_wake.sv
module sat_wake #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] route,
  input  logic         force_on,
  input  logic         clr,
  output logic         pwr,
  output logic         edge_st
);
  logic pwr_q;
  assign pwr = force_on | (|(hit & route));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      edge_st <= 1'b0;
    end else begin
      pwr_q   <= pwr;
      edge_st <= (pwr & ~pwr_q) | (edge_st & ~clr);
    end
  end
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sat_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_o,
  output logic              pwr_on_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]          idx;
  logic                      wr;
  logic                      wr_up, wr_dn, wr_stat;
  logic [CTRL_W-1:0]         ctrl_q;
  logic [NUM_CMP-1:0][W-1:0] cmp_q;
  logic [W-1:0]              key_q;
  logic [W-1:0]              up_cnt, dn_cnt;
  logic [NUM_CMP-1:0]        hit_st;
  logic                      wake_st;
  logic [STAT_W-1:0]         stat;

  assign idx     = addr_i[ADDR_W-1:2];
  assign wr      = req_i & we_i;
  assign wr_up   = wr && (idx == IDX_W'(IDX_UP));
  assign wr_dn   = wr && (idx == IDX_W'(IDX_DOWN));
  assign wr_stat = wr && (idx == IDX_W'(IDX_STAT));
  assign stat    = {wake_st, hit_st};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '1;
      key_q  <= '0;
    end else if (wr) begin
      case (idx)
        IDX_W'(IDX_CTRL): ctrl_q   <= wdata_i[CTRL_W-1:0] & CTRL_MASK;
        IDX_W'(IDX_CMPA): cmp_q[0] <= wdata_i;
        IDX_W'(IDX_CMPB): cmp_q[1] <= wdata_i;
        IDX_W'(IDX_KEY):  key_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  sat_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .clear(ctrl_q[CB_CLEAR]), .freeze(ctrl_q[CB_FREEZE]), .tick(tick_i),
    .ld_up(wr_up), .ld_dn(wr_dn), .ld_val(wdata_i),
    .up_cnt(up_cnt), .dn_cnt(dn_cnt)
  );

  sat_match #(.W(W), .N(NUM_CMP)) u_match (
    .clk(clk), .rst_n(rst_n), .up_cnt(up_cnt), .cmp_val(cmp_q),
    .clr({NUM_CMP{wr_stat}} & wdata_i[NUM_CMP-1:0]),
    .hit(hit_st)
  );

  sat_wake #(.N(NUM_CMP)) u_wake (
    .clk(clk), .rst_n(rst_n), .hit(hit_st),
    .route(ctrl_q[CB_ROUTE0 +: NUM_CMP]), .force_on(ctrl_q[CB_FORCE]),
    .clr(wr_stat & wdata_i[NUM_CMP]),
    .pwr(pwr_on_o), .edge_st(wake_st)
  );

  assign irq_o = |(hit_st & ctrl_q[CB_IRQ_EN0 +: NUM_CMP]);

  always_comb begin
    case (idx)
      IDX_W'(IDX_UP):   rdata_o = up_cnt;
      IDX_W'(IDX_DOWN): rdata_o = dn_cnt;
      IDX_W'(IDX_CMPA): rdata_o = cmp_q[0];
      IDX_W'(IDX_CMPB): rdata_o = cmp_q[1];
      IDX_W'(IDX_CTRL): rdata_o = W'(ctrl_q);
      IDX_W'(IDX_STAT): rdata_o = W'(stat);
      IDX_W'(IDX_KEY):  rdata_o = key_q;
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [7:0]   ctrl,
  input logic [W-1:0] up,
  input logic [W-1:0] down,
  input logic [W-1:0] cmp_a,
  input logic [2:0]   stat,
  input logic         cnt_wr,
  input logic         stat_wr,
  input logic         clr_a,
  input logic         irq,
  input logic         pwr
);
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl[6] && !ctrl[4] && !cnt_wr) |=>
      (up == $past(up) + W'(1)) && (down == $past(down) - W'(1)));

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !ctrl[4] && !cnt_wr) |=> ($stable(up) && $stable(down)));

  a_r5_clear_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4] |=> (up == '0 && down == '1));

  a_r6_match_set: assert property (@(posedge clk) disable iff (!rst_n)
    (up == cmp_a) |=> stat[0]);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !(stat_wr && clr_a)) |=> stat[0]);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl[0] || ctrl[1]));

  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1:0] == 2'b00) |-> !irq);

  a_r9_wake_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr) |=> stat[2]);
endmodule

bind sec_alarm_timer sat_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_i), .ctrl(ctrl_q),
  .up(up_cnt), .down(dn_cnt), .cmp_a(cmp_q[0]), .stat(stat),
  .cnt_wr(wr_up | wr_dn), .stat_wr(wr_stat), .clr_a(wdata_i[0]),
  .irq(irq_o), .pwr(pwr_on_o)
);

// File: tb/sec_alarm_timer_test.sv
`timescale 1ns/1ps
module sec_alarm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, pwr_on_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sec_alarm_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .pwr_on_o(pwr_on_o)
  );

  localparam logic [4:0] A_UP = 5'h00, A_DN = 5'h04, A_CA = 5'h08, A_CB = 5'h0C,
                         A_CTL = 5'h10, A_ST = 5'h14, A_KEY = 5'h18;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic with_tick = 1'b0);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; tick_i = with_tick;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 pwr", {31'b0, pwr_on_o}, 0);
    rd(A_UP, v);  check("R1 up", v, 32'h0);
    rd(A_DN, v);  check("R1 down", v, 32'hFFFFFFFF);
    rd(A_CA, v);  check("R1 cmpA", v, 32'hFFFFFFFF);
    rd(A_CB, v);  check("R1 cmpB", v, 32'hFFFFFFFF);
    rd(A_CTL, v); check("R1 ctrl", v, 0);
    rd(A_ST, v);  check("R1 status", v, 0);
    rd(A_KEY, v); check("R1 key", v, 0);
    rd(5'h1C, v); check("R1 unmapped", v, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    tick_n(3);
    rd(A_UP, v); check("R2 up", v, 3);
    rd(A_DN, v); check("R2 down", v, 32'hFFFFFFFC);
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    wr(A_CTL, 32'h40);
    tick_n(2);
    rd(A_UP, v); check("R3 up frozen", v, 3);
    rd(A_DN, v); check("R3 down frozen", v, 32'hFFFFFFFC);
    wr(A_UP, 100);
    wr(A_DN, ~32'd100);
    rd(A_UP, v); check("R3 load while frozen", v, 100);
    wr(A_CTL, 32'h0);
    tick_n(1);
    rd(A_UP, v); check("R2 up after load", v, 101);
    rd(A_DN, v); check("R2 down after load", v, 32'hFFFFFF9A);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(A_UP, 500, 1'b1);
    rd(A_UP, v); check("R4 write beats tick", v, 500);
    rd(A_DN, v); check("R4 other counter ticks", v, 32'hFFFFFF99);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(A_CB, 32'h1234);
    wr(A_KEY, 32'hB5C13F27);
    wr(A_CTL, 32'h10);
    tick_n(1);
    wr(A_UP, 77);
    rd(A_UP, v);  check("R5 up held", v, 0);
    rd(A_DN, v);  check("R5 down held", v, 32'hFFFFFFFF);
    rd(A_CB, v);  check("R5 cmpB kept", v, 32'h1234);
    rd(A_KEY, v); check("R10 key full width", v, 32'hB5C13F27);
    wr(A_CTL, 32'h0);
    wr(A_CB, 32'hFFFFFFFF);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(A_CTL, 32'h01);
    wr(A_CA, 2);
    tick_n(1);
    rd(A_ST, v); check("R6 no early hit", v, 0);
    tick_n(1);
    idle();
    rd(A_ST, v); check("R6 hit latched", v, 1);
    check("R7 irq on enabled hit", {31'b0, irq_o}, 1);
    wr(A_ST, 1);
    rd(A_ST, v); check("R6 clear ignored while equal", v, 1);
    wr(A_CA, 32'hFFFFFFFF);
    idle();
    rd(A_ST, v); check("R6 sticky after mismatch", v, 1);
    wr(A_ST, 1);
    rd(A_ST, v); check("R6 write-1 clears", v, 0);
    check("R7 irq drops", {31'b0, irq_o}, 0);
  endtask

  task automatic t_mask_route();
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    wr(A_CB, 2);
    idle();
    rd(A_ST, v); check("R6 cmpB hit", v, 2);
    check("R7 masked irq", {31'b0, irq_o}, 0);
    check("R8 unrouted pwr", {31'b0, pwr_on_o}, 0);
    wr(A_CTL, 32'h02);
    check("R7 late enable", {31'b0, irq_o}, 1);
    wr(A_CTL, 32'h08);
    check("R8 routed pwr", {31'b0, pwr_on_o}, 1);
    check("R7 irq off when disabled", {31'b0, irq_o}, 0);
    idle();
    rd(A_ST, v); check("R9 wake bit on routed rise", v, 6);
    wr(A_CB, 32'hFFFFFFFF);
    wr(A_ST, 7);
    rd(A_ST, v); check("R6 R9 all cleared", v, 0);
    check("R8 pwr low after clear", {31'b0, pwr_on_o}, 0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    wr(A_CTL, 32'h80);
    check("R8 forced pwr", {31'b0, pwr_on_o}, 1);
    idle();
    rd(A_ST, v); check("R9 wake bit on force", v, 4);
    wr(A_ST, 4);
    idle();
    rd(A_ST, v); check("R9 no relatch on steady high", v, 0);
    wr(A_CTL, 32'hFFFFFFFF);
    rd(A_CTL, v); check("R10 ctrl reserved bits zero", v, 32'hDF);
    wr(A_CTL, 32'h0);
  endtask

  initial begin : watchdog
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_freeze();
    t_collide();
    t_clear();
    t_match();
    t_mask_route();
    t_force();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule